// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

A 1024-word by 9-bit first-in first-out buffer with a write side and a read side, each on its own clock. Both sides have one select input. With the select high, an enabled access moves a word into or out of the storage array. With the select low, the same enabled access reaches a bank of four threshold registers instead.

The four registers form two 10-bit thresholds. The empty threshold n and the full threshold m are each built from a low byte and a 2-bit high part. A write-side pointer and a read-side pointer each step through the bank in a fixed rotation: empty low, empty high, full low, full high, and then back to empty low. Writes load the registers through the write pointer. Reads return their contents on the data output through the read pointer.

Four flags come out of the block. The almost-empty flag is registered on the read clock and the almost-full flag on the write clock. Full and empty flags are also provided. Word pointers cross between the two clock domains in Gray code through two-stage synchronizers. Each flag compares its own domain's pointer with the synchronized copy from the other domain. A flag may therefore clear a few cycles late, but it never asserts late.

Top module: `dc_fifo_pflags`

## Requirements
- R1: Words leave the read side in the same order they were written. All 9 data bits are preserved.
- R2: After reset:
  - the empty low and full low registers read back 0x007;
  - both high registers read back 0x000;
  - empty=1, full=0, almost_empty_n=0, almost_full_n=1;
  - rd_data=0.
- R3: On a wr_clk rising edge with wr_en=1 and wr_word_sel=0, the selected threshold register takes wr_data. The write-side select then advances in the order empty low (0), empty high (1), full low (2), full high (3), and wraps back to 0.
- R4: On a wr_clk rising edge with wr_en=1 and wr_word_sel=1, a word is stored. No threshold register and no select pointer changes.
- R5: A wr_clk edge with wr_en=0 writes nothing and moves no pointer, whatever the level of wr_word_sel.
- R6: On a rd_clk rising edge with rd_en=1 and rd_word_sel=0, the register chosen by the read-side select is placed on rd_data, zero-extended to 9 bits. The read-side select follows the same rotation and wrap as the write side, independently of it, and no word is removed.
- R7: almost_empty_n is low while the FIFO holds n or fewer unread words, and high when it holds n+1 or more.
- R8: almost_full_n is low while the unread count is at least 1024-m, and high when more than m locations are free.
- R9: A write to a high threshold register keeps only wr_data[1:0]. Bits [8:2] are dropped and read back as zero.
- R10: full is high while 1024 words are held. A data write while full is ignored.
- R11: empty is high while no word is held. A data read while empty is ignored and leaves rd_data and the read pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write access enable |
| wr_word_sel | input | 1 | 1: data word access, 0: threshold register access |
| wr_data | input | 9 | Write data or threshold value |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read access enable |
| rd_word_sel | input | 1 | 1: data word access, 0: threshold read-back |
| rd_data | output | 9 | Registered read data or threshold value |
| full | output | 1 | FIFO holds 1024 words (write domain) |
| empty | output | 1 | FIFO holds no word (read domain) |
| almost_empty_n | output | 1 | Low when unread count is at most n (read domain) |
| almost_full_n | output | 1 | Low when unread count is at least 1024-m (write domain) |

## Verification
The bench loads the thresholds with five writes so that the rotation wraps onto the empty low register. It writes garbage into the upper bits of a high register. A design that failed to wrap, or that kept the upper bits, would read back the wrong threshold set.

The flags are probed exactly at n versus n+1 words and at 1023-m versus 1024-m words. An off-by-one compare would flip a flag one word early or late.

The bench also pushes past full and pops past empty. It then checks that no phantom word appears and that no read pointer is lost. A design that advanced a pointer on a blocked access would show a stray word or a wrong data sequence.

// File: rtl/dc_fifo_pflags_pkg.sv
package dc_fifo_pflags_pkg;
  localparam int DATA_W   = 9;
  localparam int ADDR_W   = 10;
  localparam int LO_W     = 8;
  localparam int RST_LO   = 7;

  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } thr_sel_e;
endpackage

// File: rtl/dc_fifo_gray_sync.sv
module dc_fifo_gray_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dc_fifo_mem.sv
module dc_fifo_mem #(
  parameter int DW = 9,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dc_fifo_thr_bank.sv
module dc_fifo_thr_bank
  import dc_fifo_pflags_pkg::*;
#(
  parameter int DW     = 9,
  parameter int OFF_W  = 10,
  parameter int LOW_W  = 8,
  parameter int RST_LV = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DW-1:0]    wdata,
  input  logic [1:0]       rd_sel,
  output logic [1:0]       wr_sel,
  output logic [OFF_W-1:0] empty_thr,
  output logic [OFF_W-1:0] full_thr,
  output logic [DW-1:0]    rb_data
);
  localparam int HIGH_W = OFF_W - LOW_W;

  logic [LOW_W-1:0]  e_lo, f_lo;
  logic [HIGH_W-1:0] e_hi, f_hi;
  thr_sel_e          sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_lo  <= LOW_W'(RST_LV);
      f_lo  <= LOW_W'(RST_LV);
      e_hi  <= '0;
      f_hi  <= '0;
      sel_q <= SEL_EMPTY_LO;
    end else if (load) begin
      unique case (sel_q)
        SEL_EMPTY_LO: e_lo <= wdata[LOW_W-1:0];
        SEL_EMPTY_HI: e_hi <= wdata[HIGH_W-1:0];
        SEL_FULL_LO:  f_lo <= wdata[LOW_W-1:0];
        SEL_FULL_HI:  f_hi <= wdata[HIGH_W-1:0];
      endcase
      sel_q <= thr_sel_e'(sel_q + 2'd1);
    end
  end

  always_comb begin
    unique case (thr_sel_e'(rd_sel))
      SEL_EMPTY_LO: rb_data = DW'(e_lo);
      SEL_EMPTY_HI: rb_data = DW'(e_hi);
      SEL_FULL_LO:  rb_data = DW'(f_lo);
      SEL_FULL_HI:  rb_data = DW'(f_hi);
    endcase
  end

  assign wr_sel    = sel_q;
  assign empty_thr = {e_hi, e_lo};
  assign full_thr  = {f_hi, f_lo};
endmodule

// File: rtl/dc_fifo_pflags.sv
module dc_fifo_pflags
  import dc_fifo_pflags_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int LOWW = LO_W
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic          wr_word_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_en,
  input  logic          rd_word_sel,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          almost_empty_n,
  output logic          almost_full_n
);
  localparam int PW    = AW + 1;
  localparam int OFF_W = AW;
  localparam logic [PW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] level_of(input logic [PW-1:0] wp,
                                              input logic [PW-1:0] rp);
    return wp - rp;
  endfunction

  function automatic logic exceeds(input logic [PW-1:0] amount,
                                   input logic [OFF_W-1:0] thr);
    return amount > {1'b0, thr};
  endfunction

  // write domain
  logic [PW-1:0]    wbin, wgray, rgray_w, rbin_w, wbin_nx, wlevel_nx;
  logic             wr_push, wr_thr;
  logic [1:0]       wsel;
  logic [OFF_W-1:0] empty_thr, full_thr;
  logic [DW-1:0]    thr_rb, mem_q;
  logic             full_q, afull_n_q;

  // read domain
  logic [PW-1:0]    rbin, rgray, wgray_r, wbin_r, rbin_nx, rlevel_nx;
  logic             rd_pop, rd_thr;
  logic [1:0]       rsel;
  logic             empty_q, aempty_n_q;
  logic [DW-1:0]    rd_q;

  assign wr_push   = wr_en && wr_word_sel && !full_q;
  assign wr_thr    = wr_en && !wr_word_sel;
  assign wbin_nx   = wbin + PW'(wr_push);
  assign rbin_w    = gray2bin(rgray_w);
  assign wlevel_nx = level_of(wbin_nx, rbin_w);

  dc_fifo_thr_bank #(.DW(DW), .OFF_W(OFF_W), .LOW_W(LOWW), .RST_LV(RST_LO)) thr_i (
    .clk(wr_clk), .rst_n(rst_n), .load(wr_thr), .wdata(wr_data),
    .rd_sel(rsel), .wr_sel(wsel), .empty_thr(empty_thr),
    .full_thr(full_thr), .rb_data(thr_rb)
  );

  dc_fifo_mem #(.DW(DW), .AW(AW)) mem_i (
    .wclk(wr_clk), .we(wr_push), .waddr(wbin[AW-1:0]), .wdata(wr_data),
    .raddr(rbin[AW-1:0]), .rdata(mem_q)
  );

  dc_fifo_gray_sync #(.W(PW)) r2w_i (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
  dc_fifo_gray_sync #(.W(PW)) w2r_i (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin      <= '0;
      wgray     <= '0;
      full_q    <= 1'b0;
      afull_n_q <= 1'b1;
    end else begin
      wbin      <= wbin_nx;
      wgray     <= bin2gray(wbin_nx);
      full_q    <= (wlevel_nx == DEPTH_V);
      afull_n_q <= exceeds(DEPTH_V - wlevel_nx, full_thr);
    end
  end

  assign rd_pop    = rd_en && rd_word_sel && !empty_q;
  assign rd_thr    = rd_en && !rd_word_sel;
  assign rbin_nx   = rbin + PW'(rd_pop);
  assign wbin_r    = gray2bin(wgray_r);
  assign rlevel_nx = level_of(wbin_r, rbin_nx);

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin       <= '0;
      rgray      <= '0;
      rsel       <= 2'd0;
      empty_q    <= 1'b1;
      aempty_n_q <= 1'b0;
      rd_q       <= '0;
    end else begin
      rbin       <= rbin_nx;
      rgray      <= bin2gray(rbin_nx);
      empty_q    <= (rlevel_nx == '0);
      aempty_n_q <= exceeds(rlevel_nx, empty_thr);
      if (rd_pop) begin
        rd_q <= mem_q;
      end else if (rd_thr) begin
        rd_q <= thr_rb;
        rsel <= rsel + 2'd1;
      end
    end
  end

  assign rd_data        = rd_q;
  assign full           = full_q;
  assign empty          = empty_q;
  assign almost_empty_n = aempty_n_q;
  assign almost_full_n  = afull_n_q;
endmodule

// File: rtl/dc_fifo_pflags_chk.sv
module dc_fifo_pflags_chk #(
  parameter int PW    = 11,
  parameter int OFF_W = 10
) (
  input logic             rst_n,
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             wr_en,
  input logic             wr_word_sel,
  input logic             rd_en,
  input logic             rd_word_sel,
  input logic             full,
  input logic             empty,
  input logic             almost_empty_n,
  input logic             almost_full_n,
  input logic [PW-1:0]    wbin,
  input logic [PW-1:0]    rbin,
  input logic [1:0]       wsel,
  input logic [1:0]       rsel,
  input logic [OFF_W-1:0] empty_thr,
  input logic [OFF_W-1:0] full_thr
);
  assert_no_overflow_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && wr_word_sel && full) |=> $stable(wbin));

  assert_no_underflow_R11: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && rd_word_sel && empty) |=> $stable(rbin));

  assert_wsel_rotates_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && !wr_word_sel) |=> (wsel == $past(wsel) + 2'd1));

  assert_data_keeps_thr_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && wr_word_sel) |=> ($stable(empty_thr) && $stable(full_thr) && $stable(wsel)));

  assert_idle_write_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_en |=> ($stable(wbin) && $stable(wsel) && $stable(empty_thr) && $stable(full_thr)));

  assert_rsel_rotates_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && !rd_word_sel) |=> ((rsel == $past(rsel) + 2'd1) && $stable(rbin)));

  assert_aempty_vs_empty_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    almost_empty_n |-> !empty);

  assert_afull_vs_full_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> !almost_full_n);
endmodule

bind dc_fifo_pflags dc_fifo_pflags_chk #(.PW(PW), .OFF_W(OFF_W)) chk_i (
  .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_en(wr_en),
  .wr_word_sel(wr_word_sel), .rd_en(rd_en), .rd_word_sel(rd_word_sel),
  .full(full), .empty(empty), .almost_empty_n(almost_empty_n),
  .almost_full_n(almost_full_n), .wbin(wbin), .rbin(rbin), .wsel(wsel),
  .rsel(rsel), .empty_thr(empty_thr), .full_thr(full_thr)
);

// File: tb/dc_fifo_pflags_tb.sv
module dc_fifo_pflags_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
  localparam int DEPTH       = 1024;

  logic       rst_n = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_en = 1'b0, wr_word_sel = 1'b1, rd_en = 1'b0, rd_word_sel = 1'b1;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       full, empty, almost_empty_n, almost_full_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RCLK_PERIOD / 2) rd_clk = ~rd_clk;

  dc_fifo_pflags dut_i (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_word_sel(wr_word_sel),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_en(rd_en), .rd_word_sel(rd_word_sel),
    .rd_data(rd_data), .full(full), .empty(empty),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

  function automatic logic [8:0] pat(input int k);
    return 9'((k * 37 + 11) % 512);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cycle(input logic sel, input logic [8:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_word_sel = sel; wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0; wr_word_sel = 1'b1;
  endtask

  task automatic rd_cycle(input logic sel, output logic [8:0] d);
    @(negedge rd_clk);
    rd_en = 1'b1; rd_word_sel = sel;
    @(negedge rd_clk);
    rd_en = 1'b0; rd_word_sel = 1'b1;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic readback(input string req, input logic [8:0] e0, input logic [8:0] e1,
                          input logic [8:0] e2, input logic [8:0] e3);
    logic [8:0] v;
    rd_cycle(1'b0, v); check({req, " slot0"}, 16'(v), 16'(e0));
    rd_cycle(1'b0, v); check({req, " slot1"}, 16'(v), 16'(e1));
    rd_cycle(1'b0, v); check({req, " slot2"}, 16'(v), 16'(e2));
    rd_cycle(1'b0, v); check({req, " slot3"}, 16'(v), 16'(e3));
  endtask

  task automatic t_reset();
    check("R2 empty", 16'(empty), 16'd1);
    check("R2 full", 16'(full), 16'd0);
    check("R2 almost_empty_n", 16'(almost_empty_n), 16'd0);
    check("R2 almost_full_n", 16'(almost_full_n), 16'd1);
    check("R2 rd_data", 16'(rd_data), 16'd0);
    readback("R2 R6 defaults", 9'h007, 9'h000, 9'h007, 9'h000);
  endtask

  task automatic t_program();
    logic [8:0] v;
    // five writes: the fifth wraps onto the empty low register (R3); 0x1FC keeps bits [1:0]=0 (R9)
    wr_cycle(1'b0, 9'h003);
    wr_cycle(1'b0, 9'h1FC);
    wr_cycle(1'b0, 9'h002);
    wr_cycle(1'b0, 9'h101);
    wr_cycle(1'b0, 9'h004);
    // R5: idle edges with wr_en low, both select levels
    @(negedge wr_clk);
    wr_word_sel = 1'b0; wr_data = 9'h0AA;
    repeat (3) @(negedge wr_clk);
    wr_word_sel = 1'b1; wr_data = 9'h155;
    repeat (3) @(negedge wr_clk);
    settle();
    check("R5 idle edges store no word", 16'(empty), 16'd1);
    readback("R3 R9 R5 thresholds", 9'h004, 9'h000, 9'h002, 9'h001);
    rd_cycle(1'b0, v);
    check("R6 read select wraps", 16'(v), 16'h004);
    // put read select back at slot0
    repeat (3) rd_cycle(1'b0, v);
  endtask

  task automatic t_small();
    logic [8:0] v;
    for (int k = 0; k < 4; k++) wr_cycle(1'b1, pat(k));
    settle();
    check("R11 empty clears", 16'(empty), 16'd0);
    check("R7 four words at n=4", 16'(almost_empty_n), 16'd0);
    wr_cycle(1'b1, pat(4));
    settle();
    check("R7 five words at n=4", 16'(almost_empty_n), 16'd1);
    rd_cycle(1'b1, v);
    check("R1 word 0", 16'(v), 16'(pat(0)));
    settle();
    check("R7 back to four words", 16'(almost_empty_n), 16'd0);
    for (int k = 1; k < 5; k++) begin
      rd_cycle(1'b1, v);
      check("R1 small order", 16'(v), 16'(pat(k)));
    end
    settle();
    check("R11 empty after drain", 16'(empty), 16'd1);
    rd_cycle(1'b1, v);
    check("R11 read on empty keeps rd_data", 16'(v), 16'(pat(4)));
    wr_cycle(1'b1, 9'h1A5);
    settle();
    rd_cycle(1'b1, v);
    check("R11 pointer not moved by blocked read", 16'(v), 16'h1A5);
    settle();
    check("R11 empty again", 16'(empty), 16'd1);
  endtask

  task automatic t_fill();
    logic [8:0] v;
    int bad;
    // m = 0x102 = 258, so almost_full_n drops at 1024-258 = 766 words
    for (int k = 0; k < 765; k++) wr_cycle(1'b1, pat(k + 100));
    settle();
    check("R8 765 words", 16'(almost_full_n), 16'd1);
    wr_cycle(1'b1, pat(765 + 100));
    settle();
    check("R8 766 words", 16'(almost_full_n), 16'd0);
    for (int k = 766; k < DEPTH - 1; k++) wr_cycle(1'b1, pat(k + 100));
    settle();
    check("R10 not full at 1023", 16'(full), 16'd0);
    wr_cycle(1'b1, pat(DEPTH - 1 + 100));
    settle();
    check("R10 full at 1024", 16'(full), 16'd1);
    check("R8 low while full", 16'(almost_full_n), 16'd0);
    wr_cycle(1'b1, 9'h155);
    readback("R4 thresholds after data writes", 9'h004, 9'h000, 9'h002, 9'h001);
    bad = 0;
    for (int k = 0; k < DEPTH; k++) begin
      rd_cycle(1'b1, v);
      if (v !== pat(k + 100)) begin
        bad++;
        if (bad < 4) $display("FAIL R1 fill word %0d actual=%0h expected=%0h", k, v, pat(k + 100));
      end
    end
    check("R1 full depth order (miscompare count)", 16'(bad), 16'd0);
    settle();
    check("R10 blocked write left no word", 16'(empty), 16'd1);
    check("R8 high when drained", 16'(almost_full_n), 16'd1);
  endtask

  initial begin
    repeat (5) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (3) @(negedge rd_clk);
    fork
      begin
        t_reset();
        t_program();
        t_small();
        t_fill();
      end
      begin
        repeat (150000) @(posedge wr_clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule